// File: doc/BRIEF.md
# Fractional-N Ratio Source Selector

This block decides which ratio word drives the fractional-N divider of a frequency synthesizer. There are two candidates. The first is a static word taken from a bank of user ratio registers. The second is a dynamic word produced by an external digital PLL that tracks an input clock. A second pointer into the same bank picks the word handed to that digital PLL as its output-to-input ratio target.

The choice is made in one of two ways. It is manual, through a source-select bit, when both pointers hold the same index. It becomes automatic as soon as the pointers differ. In automatic mode the choice follows whether the input clock is present. Presence is measured in the system-clock domain: a toggle from the input-clock domain is synchronized, and the clock counts as lost once a programmable number of system cycles passes with no toggle. After loss, the block holds the dynamic word for two further system cycles before it falls back to the static word.

Every change of source raises a one-cycle relock request and drops the lock status until the external lock indication comes back. The selection state machine has five states:

- `ST_UNCFG`: reset state. The source is static and nothing is requested. The first configuration write leaves this state.
- `ST_STATIC`: the static word is selected.
- `ST_DYNAMIC`: the digital-PLL word is selected.
- `ST_WAIT1` and `ST_WAIT2`: the two hold cycles after loss. The dynamic word is still selected.

Its transitions are:

- `UNCFG->STATIC` or `UNCFG->DYNAMIC`: on the first configuration.
- `STATIC->DYNAMIC`: when the dynamic source is wanted.
- `DYNAMIC->WAIT1`: automatic mode and the clock is lost.
- `DYNAMIC->STATIC`: manual mode selects static.
- `WAIT1->WAIT2`: the first hold cycle ends.
- `WAIT1->STATIC`: manual mode was chosen during the hold.
- `WAIT2->STATIC`: the second hold cycle ends.
- `WAIT1/WAIT2->DYNAMIC`: the dynamic source is wanted again. This return raises no request.

Top module: `fracn_src_sel`

## Requirements
- R1: After reset and until the first configuration write, `use_dynamic`, `relock_req` and `locked` stay 0 and `fracn_ratio` equals ratio word 0, even while the input clock runs.
- R2: When the two pointers are equal, the mode is manual. `cfg_src_dyn`=1 selects `dpll_ratio` and `cfg_src_dyn`=0 selects the word indexed by the static pointer.
- R3: When the pointers differ, the mode is automatic and `cfg_src_dyn` has no effect. With the clock present the dynamic word is used, whatever the value of the bit.
- R4: `dpll_target` equals the ratio word indexed by the lock pointer.
- R5: In automatic mode with the input clock absent, `fracn_ratio` equals the word indexed by the static pointer.
- R6: `clkin_present` is 1 while the input clock toggles. It falls once `loss_window` system cycles pass without a synchronized toggle.
- R7: After `clkin_present` falls in automatic dynamic operation, `use_dynamic` stays 1 for two more system edges and falls on the third edge.
- R8: `relock_req` is a one-cycle pulse. It is raised on every change of `use_dynamic` and on leaving the unconfigured state.
- R9: `locked` clears in the cycle of `relock_req`. It sets on the edge after which `lock_in` is seen high.
- R10: In automatic mode, when the input clock returns, the block switches to the dynamic word one edge after `clkin_present` rises, with a relock pulse.
- R11: `fracn_ratio` is registered: a change of `dpll_ratio` while dynamic appears after one system edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_in | input | 1 | Input clock whose presence is monitored |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_static_ptr | input | 2 | Static-ratio pointer |
| cfg_lock_ptr | input | 2 | Lock-clock ratio pointer |
| cfg_src_dyn | input | 1 | Manual source bit, 1 = dynamic |
| ratio_bank | input | 128 | Four 32-bit ratio words, word i at bits [32i+31:32i] |
| dpll_ratio | input | 32 | Dynamic ratio from the digital PLL |
| loss_window | input | 16 | Loss timeout in system cycles |
| lock_in | input | 1 | External lock indication |
| fracn_ratio | output | 32 | Registered ratio for the synthesizer |
| dpll_target | output | 32 | Ratio word handed to the digital PLL |
| use_dynamic | output | 1 | 1 when the dynamic source is selected |
| clkin_present | output | 1 | Input clock detected |
| relock_req | output | 1 | One-cycle lock reacquire request |
| locked | output | 1 | Lock status |

## Verification
The hardest situation to reach is the two-cycle hold after clock loss. It needs automatic mode, an established dynamic selection, and a presence flag that falls only after the loss window has expired. The bench first configures differing pointers while the input clock runs, and waits for the dynamic selection and its relock pulse. It then stops the input clock and waits for the presence flag to drop. From that cycle it samples `use_dynamic` and `relock_req` edge by edge. Restarting the clock afterwards covers the return path.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [2:0] {
        ST_UNCFG   = 3'd0,
        ST_STATIC  = 3'd1,
        ST_DYNAMIC = 3'd2,
        ST_WAIT1   = 3'd3,
        ST_WAIT2   = 3'd4
    } src_state_e;

    function automatic logic state_is_dyn(input src_state_e s);
        return (s == ST_DYNAMIC) || (s == ST_WAIT1) || (s == ST_WAIT2);
    endfunction

endpackage

// File: rtl/fracn_clkin_detect.sv
module fracn_clkin_detect #(
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_in,
    input  logic [CNT_W-1:0] loss_window,
    output logic             present
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic             tog;
    logic [SH_W-1:0]  sync_q;
    logic [CNT_W-1:0] idle_cnt;
    logic             seen;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SH_W-2:0], tog};
    end

    assign seen = sync_q[SH_W-1] ^ sync_q[SH_W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            present  <= 1'b0;
        end else if (seen) begin
            idle_cnt <= '0;
            present  <= 1'b1;
        end else if (idle_cnt >= loss_window) begin
            present  <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fracn_cfg_regs.sv
module fracn_cfg_regs #(
    parameter int NUM_RATIOS = 4,
    parameter int RATIO_W = 32,
    localparam int PTR_W = $clog2(NUM_RATIOS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [PTR_W-1:0]              static_ptr_in,
    input  logic [PTR_W-1:0]              lock_ptr_in,
    input  logic                          src_dyn_in,
    input  logic [NUM_RATIOS*RATIO_W-1:0] bank,
    output logic                          cfg_valid,
    output logic                          auto_mode,
    output logic                          src_dyn,
    output logic [RATIO_W-1:0]            static_ratio,
    output logic [RATIO_W-1:0]            lock_ratio
);
    logic [PTR_W-1:0]   static_ptr_q;
    logic [PTR_W-1:0]   lock_ptr_q;
    logic [RATIO_W-1:0] words [NUM_RATIOS];

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_unpack
        assign words[i] = bank[i*RATIO_W +: RATIO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            static_ptr_q <= '0;
            lock_ptr_q   <= '0;
            src_dyn      <= 1'b0;
            cfg_valid    <= 1'b0;
        end else if (we) begin
            static_ptr_q <= static_ptr_in;
            lock_ptr_q   <= lock_ptr_in;
            src_dyn      <= src_dyn_in;
            cfg_valid    <= 1'b1;
        end
    end

    assign auto_mode    = (static_ptr_q != lock_ptr_q);
    assign static_ratio = words[static_ptr_q];
    assign lock_ratio   = words[lock_ptr_q];
endmodule

// File: rtl/fracn_src_fsm.sv
module fracn_src_fsm
    import fracn_pkg::*;
#(
    parameter int RATIO_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               auto_mode,
    input  logic               src_dyn,
    input  logic               present,
    input  logic               lock_in,
    input  logic [RATIO_W-1:0] static_ratio,
    input  logic [RATIO_W-1:0] dyn_ratio,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               use_dyn,
    output logic               relock,
    output logic               locked
);
    src_state_e state_q, state_d;
    logic       want_dyn;
    logic       change;

    assign want_dyn = auto_mode ? present : src_dyn;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG:   if (cfg_valid) state_d = want_dyn ? ST_DYNAMIC : ST_STATIC;
            ST_STATIC:  if (want_dyn)  state_d = ST_DYNAMIC;
            ST_DYNAMIC: if (!want_dyn) state_d = auto_mode ? ST_WAIT1 : ST_STATIC;
            ST_WAIT1:   if (want_dyn)  state_d = ST_DYNAMIC;
                        else           state_d = auto_mode ? ST_WAIT2 : ST_STATIC;
            ST_WAIT2:   state_d = want_dyn ? ST_DYNAMIC : ST_STATIC;
            default:    state_d = ST_UNCFG;
        endcase
    end

    assign change = ((state_q == ST_UNCFG) && (state_d != ST_UNCFG))
                  || (state_is_dyn(state_d) != state_is_dyn(state_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNCFG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_out <= '0;
            use_dyn   <= 1'b0;
            relock    <= 1'b0;
            locked    <= 1'b0;
        end else begin
            ratio_out <= state_is_dyn(state_d) ? dyn_ratio : static_ratio;
            use_dyn   <= state_is_dyn(state_d);
            relock    <= change;
            if (change)
                locked <= 1'b0;
            else if ((state_d != ST_UNCFG) && lock_in)
                locked <= 1'b1;
        end
    end
endmodule

// File: rtl/fracn_src_sel.sv
module fracn_src_sel #(
    parameter int NUM_RATIOS = 4,
    parameter int RATIO_W = 32,
    parameter int CNT_W = 16,
    localparam int PTR_W = $clog2(NUM_RATIOS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clk_in,
    input  logic                          cfg_we,
    input  logic [PTR_W-1:0]              cfg_static_ptr,
    input  logic [PTR_W-1:0]              cfg_lock_ptr,
    input  logic                          cfg_src_dyn,
    input  logic [NUM_RATIOS*RATIO_W-1:0] ratio_bank,
    input  logic [RATIO_W-1:0]            dpll_ratio,
    input  logic [CNT_W-1:0]              loss_window,
    input  logic                          lock_in,
    output logic [RATIO_W-1:0]            fracn_ratio,
    output logic [RATIO_W-1:0]            dpll_target,
    output logic                          use_dynamic,
    output logic                          clkin_present,
    output logic                          relock_req,
    output logic                          locked
);
    logic               cfg_valid;
    logic               auto_mode;
    logic               src_dyn;
    logic [RATIO_W-1:0] static_ratio;

    fracn_clkin_detect #(.CNT_W(CNT_W)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_in      (clk_in),
        .loss_window (loss_window),
        .present     (clkin_present)
    );

    fracn_cfg_regs #(.NUM_RATIOS(NUM_RATIOS), .RATIO_W(RATIO_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (cfg_we),
        .static_ptr_in (cfg_static_ptr),
        .lock_ptr_in   (cfg_lock_ptr),
        .src_dyn_in    (cfg_src_dyn),
        .bank          (ratio_bank),
        .cfg_valid     (cfg_valid),
        .auto_mode     (auto_mode),
        .src_dyn       (src_dyn),
        .static_ratio  (static_ratio),
        .lock_ratio    (dpll_target)
    );

    fracn_src_fsm #(.RATIO_W(RATIO_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .auto_mode    (auto_mode),
        .src_dyn      (src_dyn),
        .present      (clkin_present),
        .lock_in      (lock_in),
        .static_ratio (static_ratio),
        .dyn_ratio    (dpll_ratio),
        .ratio_out    (fracn_ratio),
        .use_dyn      (use_dynamic),
        .relock       (relock_req),
        .locked       (locked)
    );
endmodule

// File: rtl/fracn_src_sel_chk.sv
module fracn_src_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_valid,
    input logic auto_mode,
    input logic use_dyn,
    input logic relock,
    input logic locked,
    input logic present
);
    AST_RELOCK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !relock); // R8
    AST_RELOCK_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (use_dyn != $past(use_dyn)) |-> relock); // R8
    AST_LOCK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        relock |-> !locked); // R9
    AST_UNCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (!relock && !use_dyn && !locked)); // R1
    AST_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(use_dyn) && auto_mode) |->
            (!$past(present, 1) && !$past(present, 2) && !$past(present, 3))); // R7
endmodule

bind fracn_src_sel fracn_src_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .auto_mode (auto_mode),
    .use_dyn   (use_dynamic),
    .relock    (relock_req),
    .locked    (locked),
    .present   (clkin_present)
);

// File: tb/fracn_src_sel_tb.sv
module fracn_src_sel_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_in = 1'b0;
    logic         clkin_run = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_static_ptr = '0;
    logic [1:0]   cfg_lock_ptr = '0;
    logic         cfg_src_dyn = 1'b0;
    logic [127:0] ratio_bank;
    logic [31:0]  dpll_ratio = 32'hDEAD_0001;
    logic [15:0]  loss_window = 16'd8;
    logic         lock_in = 1'b0;
    logic [31:0]  fracn_ratio, dpll_target;
    logic         use_dynamic, clkin_present, relock_req, locked;

    int vectors = 0;
    int miscompares = 0;

    function automatic logic [31:0] word(input int i);
        return 32'h1000_0000 + i * 32'h0111_1111;
    endfunction

    initial for (int i = 0; i < 4; i++) ratio_bank[i*32 +: 32] = word(i);

    always #10 clk = ~clk;
    always begin
        #30;
        if (clkin_run) clk_in = ~clk_in;
    end

    fracn_src_sel u_dut (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .cfg_we(cfg_we),
        .cfg_static_ptr(cfg_static_ptr), .cfg_lock_ptr(cfg_lock_ptr),
        .cfg_src_dyn(cfg_src_dyn), .ratio_bank(ratio_bank),
        .dpll_ratio(dpll_ratio), .loss_window(loss_window), .lock_in(lock_in),
        .fracn_ratio(fracn_ratio), .dpll_target(dpll_target),
        .use_dynamic(use_dynamic), .clkin_present(clkin_present),
        .relock_req(relock_req), .locked(locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] sp, input logic [1:0] lp, input logic sd);
        cfg_static_ptr = sp;
        cfg_lock_ptr = lp;
        cfg_src_dyn = sd;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        int pulses = 0;
        int dyn = 0;
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        lock_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (relock_req) pulses++;
            if (use_dynamic) dyn++;
        end
        chk("R1 relock pulses before config", pulses, 0);
        chk("R1 dynamic cycles before config", dyn, 0);
        chk("R1 locked before config", locked, 0);
        chk("R1 ratio before config", fracn_ratio, word(0));
        chk("R6 present while running", clkin_present, 1);
        lock_in = 1'b0;
    endtask

    task automatic t_manual();
        write_cfg(2'd2, 2'd2, 1'b1);
        chk("R2 manual dynamic select", use_dynamic, 1);
        chk("R2 manual dynamic ratio", fracn_ratio, dpll_ratio);
        chk("R8 relock on first config", relock_req, 1);
        tick();
        chk("R8 relock one cycle", relock_req, 0);
        lock_in = 1'b1;
        tick();
        chk("R9 locked after lock_in", locked, 1);
        dpll_ratio = 32'hCAFE_0002;
        tick();
        chk("R11 registered dynamic follow", fracn_ratio, 32'hCAFE_0002);
        write_cfg(2'd2, 2'd2, 1'b0);
        chk("R2 manual static select", use_dynamic, 0);
        chk("R2 manual static ratio", fracn_ratio, word(2));
        chk("R8 relock on manual switch", relock_req, 1);
        chk("R9 locked cleared with relock", locked, 0);
        tick();
        chk("R9 locked returns", locked, 1);
    endtask

    task automatic t_auto_present();
        write_cfg(2'd1, 2'd3, 1'b0);
        chk("R3 auto ignores static bit", use_dynamic, 1);
        chk("R3 auto dynamic ratio", fracn_ratio, dpll_ratio);
        chk("R4 dpll target from lock pointer", dpll_target, word(3));
        chk("R8 relock on auto switch", relock_req, 1);
    endtask

    task automatic t_loss();
        int guard = 0;
        int pulses = 0;
        clkin_run = 1'b0;
        while (clkin_present && guard < 200) begin
            tick();
            guard++;
        end
        chk("R6 present falls after window", clkin_present, 0);
        chk("R7 dynamic held at loss", use_dynamic, 1);
        tick();
        chk("R7 dynamic held edge 1", use_dynamic, 1);
        tick();
        chk("R7 dynamic held edge 2", use_dynamic, 1);
        tick();
        chk("R7 static on edge 3", use_dynamic, 0);
        chk("R8 relock on loss switch", relock_req, 1);
        chk("R5 static ratio when absent", fracn_ratio, word(1));
        write_cfg(2'd1, 2'd3, 1'b1);
        for (int k = 0; k < 5; k++) begin
            tick();
            if (relock_req || use_dynamic) pulses++;
        end
        chk("R3 source bit ignored when absent", pulses, 0);
        chk("R5 ratio stays static", fracn_ratio, word(1));
    endtask

    task automatic t_regain();
        int guard = 0;
        clkin_run = 1'b1;
        while (!clkin_present && guard < 200) begin
            tick();
            guard++;
        end
        chk("R6 present returns", clkin_present, 1);
        chk("R10 not yet dynamic", use_dynamic, 0);
        tick();
        chk("R10 dynamic after return", use_dynamic, 1);
        chk("R10 relock on return", relock_req, 1);
        chk("R10 dynamic ratio after return", fracn_ratio, dpll_ratio);
    endtask

    initial begin
        #4000000;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1 reset use_dynamic", use_dynamic, 0);
        chk("R1 reset relock", relock_req, 0);
        t_reset();
        t_manual();
        t_auto_present();
        t_loss();
        t_regain();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule